// File: doc/BRIEF.md
# Trap Dispatch and Handler Vector Unit

This block takes one pending trap at a time and decides how the processor must handle it. From the trap number, the current trap level, the privilege bits and a per-trap routing table, it picks one of four handling modes. The modes are recovery, hyperprivileged, privileged and the terminal error state. It then computes the first three fetch addresses of the handler from the matching base register. It also tells the state-save unit whether the trap lands at the hyperprivileged level. The save itself happens elsewhere.

A request is offered with `req_valid`. It is taken on a rising clock edge when `req_ready` is high. `req_ready` stays high until the block enters the error state, and from then on it stays low until reset. The result side cannot be stalled. One cycle after a request is taken, `out_valid` pulses for one cycle. The result outputs then keep their values until the next result. The routing table holds one bit for each current privilege level, indexed user=0, privileged=1, hyperprivileged=2. A 1 in that bit asks for a hyperprivileged handler and a 0 asks for a privileged one.

Top module: `trap_dispatch`

## Requirements
- R1: The current level is hyperprivileged when `hp_priv` is 1. Otherwise it is privileged when `ps_priv` is 1, and otherwise it is user. The routing bit `route_tbl[level]` (user=0, privileged=1, hyperprivileged=2) selects the target, with 1 meaning hyperprivileged.
- R2: When `hp_red` is 1 or `req_tl` equals MAX_TL-1, the result has mode 0 (recovery), vector trap number 5, `out_to_hyp`=1, and PC equal to 0xFF_F000_0000 ORed with the low 8 bits of (vector trap number << 5). With the defaults this PC is 0xFF_F000_00A0. This check has priority over every other rule.
- R3: When `req_tl` is MAX_TL or greater and R2 does not apply, the result has mode 3 (error) with PC, NPC, NNPC, trap number and `out_to_hyp` all zero. `error_state` and `req_ready`=0 then hold until reset, and later requests produce no result.
- R4: When `req_tl` is greater than MAX_PTL and the target is privileged, the trap escalates to mode 1 (hyperprivileged) with vector trap number 2 and `out_to_hyp`=1.
- R5: A hyperprivileged target, or a privileged target whose trap number is 384 or more, gives mode 1 with the request's own trap number and `out_to_hyp`=1.
- R6: All other traps give mode 2 (privileged) with the request's trap number and `out_to_hyp`=0.
- R7: The hyperprivileged PC is `htba_hi` on bits 63:14, followed by (trap number << 5) on bits 13:0.
- R8: The privileged PC is `tba_hi` on bits 63:15, then bit 14 set when `req_tl` is nonzero (the new level is above 1), then (trap number << 5) on bits 13:0.
- R9: For every mode other than error, NPC equals PC+4 and NNPC equals PC+8.
- R10: `out_valid` is high in exactly the cycle after each accepted request. After reset, `out_valid` and `error_state` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Trap request offered |
| req_ready | output | 1 | Request can be taken (low in error state) |
| req_tt | input | 9 | Trap number |
| req_tl | input | 3 | Current trap level |
| ps_priv | input | 1 | Privileged bit of the processor state |
| hp_priv | input | 1 | Hyperprivileged bit of the hypervisor state |
| hp_red | input | 1 | Recovery-mode bit of the hypervisor state |
| route_tbl | input | 3 | Per-trap target bits indexed by current level |
| tba_hi | input | 49 | Privileged trap base, bits 63:15 |
| htba_hi | input | 50 | Hyperprivileged trap base, bits 63:14 |
| out_valid | output | 1 | One-cycle result strobe |
| out_mode | output | 2 | 0 recovery, 1 hyperprivileged, 2 privileged, 3 error |
| out_tt | output | 9 | Trap number used for vectoring |
| out_to_hyp | output | 1 | Handler runs hyperprivileged (for the state-save unit) |
| out_pc | output | 64 | Handler PC |
| out_npc | output | 64 | Handler next PC |
| out_nnpc | output | 64 | Handler PC after next |
| error_state | output | 1 | Sticky error state |

## Verification
The bench uses the default parameters: a maximum trap level of 6, a privileged ceiling of 2, a 9-bit trap number and 64-bit addresses. With these values a handful of requests reaches every level boundary. Level 2 must stay privileged, level 3 escalates to the watchdog vector, level 5 forces recovery and level 6 is terminal. Trap numbers 383 and 384 sit on either side of the escalation floor. The error case runs last because it locks the block.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;

  typedef enum logic [1:0] {
    LVL_USER = 2'd0,
    LVL_PRIV = 2'd1,
    LVL_HYP  = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    MODE_RED  = 2'd0,
    MODE_HYP  = 2'd1,
    MODE_PRIV = 2'd2,
    MODE_ERR  = 2'd3
  } mode_e;

  localparam int RED_TT       = 5;
  localparam int WDOG_TT      = 2;
  localparam int HYP_TT_FLOOR = 384;
  localparam int VEC_SHIFT    = 5;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_vec_pkg::*;
#(
  parameter int TT_W    = 9,
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2
) (
  input  logic [TT_W-1:0] tt,
  input  logic [TL_W-1:0] tl,
  input  logic            ps_priv,
  input  logic            hp_priv,
  input  logic            hp_red,
  input  logic [2:0]      route_tbl,
  output mode_e           mode,
  output logic [TT_W-1:0] vec_tt,
  output logic            to_hyp
);

  localparam logic [TL_W-1:0] TL_RED   = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR   = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PCEIL = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_FLOOR = TT_W'(HYP_TT_FLOOR);

  lvl_e cur;
  logic tgt_hyp;

  always_comb begin
    if (hp_priv)      cur = LVL_HYP;
    else if (ps_priv) cur = LVL_PRIV;
    else              cur = LVL_USER;
  end

  assign tgt_hyp = route_tbl[cur];

  always_comb begin
    mode   = MODE_PRIV;
    vec_tt = tt;
    to_hyp = 1'b0;
    if (hp_red || tl == TL_RED) begin
      mode   = MODE_RED;
      vec_tt = TT_W'(RED_TT);
      to_hyp = 1'b1;
    end else if (tl >= TL_ERR) begin
      mode   = MODE_ERR;
      vec_tt = '0;
    end else if (tl > TL_PCEIL && !tgt_hyp) begin
      mode   = MODE_HYP;
      vec_tt = TT_W'(WDOG_TT);
      to_hyp = 1'b1;
    end else if (tgt_hyp || tt >= TT_FLOOR) begin
      mode   = MODE_HYP;
      to_hyp = 1'b1;
    end
  end

endmodule

// File: rtl/trap_vec_addr.sv
module trap_vec_addr
  import trap_vec_pkg::*;
#(
  parameter int              ADDR_W     = 64,
  parameter int              TT_W       = 9,
  parameter int              TL_W       = 3,
  parameter int              INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  mode_e                      mode,
  input  logic [TT_W-1:0]            vec_tt,
  input  logic [TL_W-1:0]            tl,
  input  logic [ADDR_W-TT_W-7:0]     tba_hi,
  input  logic [ADDR_W-TT_W-6:0]     htba_hi,
  output logic [ADDR_W-1:0]          pc,
  output logic [ADDR_W-1:0]          npc,
  output logic [ADDR_W-1:0]          nnpc
);

  localparam int OFF_W = TT_W + VEC_SHIFT;
  localparam int NSEQ  = 3;

  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] seq [NSEQ];

  assign off = {vec_tt, {VEC_SHIFT{1'b0}}};

  always_comb begin
    case (mode)
      MODE_RED:  base = RED_BASE | {{(ADDR_W-8){1'b0}}, off[7:0]};
      MODE_HYP:  base = {htba_hi, off};
      MODE_PRIV: base = {tba_hi, (tl != '0), off};
      default:   base = '0;
    endcase
  end

  for (genvar i = 0; i < NSEQ; i++) begin : g_seq
    assign seq[i] = (mode == MODE_ERR) ? '0 : base + ADDR_W'(i * INSN_BYTES);
  end

  assign pc   = seq[0];
  assign npc  = seq[1];
  assign nnpc = seq[2];

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_vec_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int TT_W       = 9,
  parameter int MAX_TL     = 6,
  parameter int MAX_PTL    = 2,
  parameter int TL_W       = $clog2(MAX_TL + 1),
  parameter int INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [TT_W-1:0]        req_tt,
  input  logic [TL_W-1:0]        req_tl,
  input  logic                   ps_priv,
  input  logic                   hp_priv,
  input  logic                   hp_red,
  input  logic [2:0]             route_tbl,
  input  logic [ADDR_W-TT_W-7:0] tba_hi,
  input  logic [ADDR_W-TT_W-6:0] htba_hi,
  output logic                   out_valid,
  output logic [1:0]             out_mode,
  output logic [TT_W-1:0]        out_tt,
  output logic                   out_to_hyp,
  output logic [ADDR_W-1:0]      out_pc,
  output logic [ADDR_W-1:0]      out_npc,
  output logic [ADDR_W-1:0]      out_nnpc,
  output logic                   error_state
);

  localparam logic [ADDR_W-1:0] RED_PC =
    RED_BASE | ADDR_W'((RED_TT << VEC_SHIFT) & 255);

  mode_e             mode_c, mode_q;
  logic [TT_W-1:0]   tt_c, tt_q;
  logic              hyp_c, hyp_q;
  logic [ADDR_W-1:0] pc_c, npc_c, nnpc_c;
  logic [ADDR_W-1:0] pc_q, npc_q, nnpc_q;
  logic              vld_q, err_q, take;

  assign req_ready = !err_q;
  assign take      = req_valid && req_ready;

  trap_route #(
    .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_route (
    .tt(req_tt), .tl(req_tl), .ps_priv(ps_priv), .hp_priv(hp_priv),
    .hp_red(hp_red), .route_tbl(route_tbl),
    .mode(mode_c), .vec_tt(tt_c), .to_hyp(hyp_c)
  );

  trap_vec_addr #(
    .ADDR_W(ADDR_W), .TT_W(TT_W), .TL_W(TL_W),
    .INSN_BYTES(INSN_BYTES), .RED_BASE(RED_BASE)
  ) u_addr (
    .mode(mode_c), .vec_tt(tt_c), .tl(req_tl),
    .tba_hi(tba_hi), .htba_hi(htba_hi),
    .pc(pc_c), .npc(npc_c), .nnpc(nnpc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= MODE_PRIV;
      tt_q   <= '0;
      hyp_q  <= 1'b0;
      pc_q   <= '0;
      npc_q  <= '0;
      nnpc_q <= '0;
    end else begin
      vld_q <= take;
      if (take) begin
        mode_q <= mode_c;
        tt_q   <= tt_c;
        hyp_q  <= hyp_c;
        pc_q   <= pc_c;
        npc_q  <= npc_c;
        nnpc_q <= nnpc_c;
        if (mode_c == MODE_ERR) err_q <= 1'b1;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_mode    = mode_q;
  assign out_tt      = tt_q;
  assign out_to_hyp  = hyp_q;
  assign out_pc      = pc_q;
  assign out_npc     = npc_q;
  assign out_nnpc    = nnpc_q;
  assign error_state = err_q;

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> out_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !out_valid);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_state |=> error_state);

  // R3
  err_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == MODE_ERR) |-> (error_state && !req_ready));

  // R2
  red_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == MODE_RED) |-> (out_pc == RED_PC && out_to_hyp));

  // R9
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode != MODE_ERR) |->
      (out_npc == out_pc + ADDR_W'(INSN_BYTES) &&
       out_nnpc == out_npc + ADDR_W'(INSN_BYTES)));

  // R6
  priv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == MODE_PRIV) |-> !out_to_hyp);

endmodule

// File: tb/tb_trap_dispatch.sv
module tb_trap_dispatch;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [8:0]  req_tt = '0;
  logic [2:0]  req_tl = '0;
  logic        ps_priv = 1'b0, hp_priv = 1'b0, hp_red = 1'b0;
  logic [2:0]  route_tbl = '0;
  logic [63:0] tba  = 64'h1234_5678_9ABC_DEF0;
  logic [63:0] htba = 64'hCAFE_0000_7777_5555;
  logic        out_valid, out_to_hyp, error_state;
  logic [1:0]  out_mode;
  logic [8:0]  out_tt;
  logic [63:0] out_pc, out_npc, out_nnpc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [1:0]  exp_mode_q [$];
  logic [8:0]  exp_tt_q   [$];
  logic        exp_hyp_q  [$];
  logic [63:0] exp_pc_q   [$];
  string       exp_tag_q  [$];

  trap_dispatch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tt(req_tt), .req_tl(req_tl), .ps_priv(ps_priv), .hp_priv(hp_priv),
    .hp_red(hp_red), .route_tbl(route_tbl),
    .tba_hi(tba[63:15]), .htba_hi(htba[63:14]),
    .out_valid(out_valid), .out_mode(out_mode), .out_tt(out_tt),
    .out_to_hyp(out_to_hyp), .out_pc(out_pc), .out_npc(out_npc),
    .out_nnpc(out_nnpc), .error_state(error_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Expected result, built from the requirement text
  task automatic model(input logic [8:0] tt, input logic [2:0] tl,
                       input logic ps, input logic hp, input logic red,
                       input logic [2:0] tbl,
                       output logic [1:0] m, output logic [8:0] vt,
                       output logic h, output logic [63:0] pc);
    int lvl;
    logic tgt;
    lvl = hp ? 2 : (ps ? 1 : 0);
    tgt = tbl[lvl];
    if (red || tl == 3'd5) begin
      m = 2'd0; vt = 9'd5; h = 1'b1;
    end else if (tl >= 3'd6) begin
      m = 2'd3; vt = 9'd0; h = 1'b0;
    end else if (tl > 3'd2 && !tgt) begin
      m = 2'd1; vt = 9'd2; h = 1'b1;
    end else if (tgt || tt >= 9'd384) begin
      m = 2'd1; vt = tt; h = 1'b1;
    end else begin
      m = 2'd2; vt = tt; h = 1'b0;
    end
    case (m)
      2'd0: pc = 64'hFF_F000_0000 | ((64'(vt) << 5) & 64'hFF);
      2'd1: pc = (htba & ~64'h3FFF) | ((64'(vt) << 5) & 64'h3FFF);
      2'd2: pc = (tba & ~64'h7FFF) | ((tl != 0) ? 64'h4000 : 64'h0)
                 | ((64'(vt) << 5) & 64'h3FFF);
      default: pc = 64'h0;
    endcase
  endtask

  task automatic send(logic [8:0] tt, logic [2:0] tl, logic ps, logic hp,
                      logic red, logic [2:0] tbl, string tag);
    logic [1:0] m; logic [8:0] vt; logic h; logic [63:0] pc;
    @(negedge clk);
    req_valid = 1'b1; req_tt = tt; req_tl = tl;
    ps_priv = ps; hp_priv = hp; hp_red = red; route_tbl = tbl;
    if (req_ready) begin
      model(tt, tl, ps, hp, red, tbl, m, vt, h, pc);
      exp_mode_q.push_back(m); exp_tt_q.push_back(vt);
      exp_hyp_q.push_back(h);  exp_pc_q.push_back(pc);
      exp_tag_q.push_back(tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard on each result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_mode_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected result actual=1 expected=0");
      end else begin
        string t;
        logic [63:0] epc;
        logic [1:0] em;
        t = exp_tag_q.pop_front();
        em = exp_mode_q.pop_front();
        epc = exp_pc_q.pop_front();
        chk({t, " mode"}, 64'(out_mode), 64'(em));
        chk({t, " tt"}, 64'(out_tt), 64'(exp_tt_q.pop_front()));
        chk({t, " to_hyp"}, 64'(out_to_hyp), 64'(exp_hyp_q.pop_front()));
        chk({t, " pc"}, out_pc, epc);
        chk({"R9 npc ", t}, out_npc, (em == 2'd3) ? 64'h0 : epc + 64'd4);
        chk({"R9 nnpc ", t}, out_nnpc, (em == 2'd3) ? 64'h0 : epc + 64'd8);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      report();
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset out_valid", 64'(out_valid), 64'd0);
    chk("R10 reset ready", 64'(req_ready), 64'd1);
    chk("R3 reset error_state", 64'(error_state), 64'd0);

    send(9'h024, 3'd0, 0, 0, 0, 3'b000, "R6 R8 user tl0");
    send(9'h024, 3'd1, 1, 0, 0, 3'b000, "R8 priv tl1 bit14");
    idle(1);
    send(9'd384, 3'd0, 0, 0, 0, 3'b000, "R5 tt384 floor");
    send(9'd383, 3'd0, 0, 0, 0, 3'b000, "R6 tt383 below floor");
    send(9'h030, 3'd1, 0, 1, 0, 3'b100, "R1 R7 hyp current");
    send(9'h030, 3'd1, 1, 1, 0, 3'b011, "R1 hpriv wins over table");
    send(9'h011, 3'd0, 1, 0, 0, 3'b010, "R1 priv index");
    send(9'h041, 3'd3, 1, 0, 0, 3'b000, "R4 watchdog tl3");
    send(9'h041, 3'd2, 1, 0, 0, 3'b000, "R4 no watchdog tl2");
    send(9'h041, 3'd4, 0, 0, 0, 3'b001, "R5 hyp target tl4");
    send(9'h068, 3'd1, 0, 1, 1, 3'b111, "R2 red bit");
    send(9'h068, 3'd5, 0, 0, 0, 3'b000, "R2 tl max-1");
    idle(2);
    chk("R3 no error yet", 64'(error_state), 64'd0);
    send(9'h068, 3'd6, 0, 0, 0, 3'b000, "R3 tl max");
    idle(2);
    chk("R3 error set", 64'(error_state), 64'd1);
    chk("R3 ready low", 64'(req_ready), 64'd0);
    send(9'h024, 3'd0, 0, 0, 0, 3'b000, "R3 ignored");
    idle(3);
    chk("R3 still error", 64'(error_state), 64'd1);
    chk("R3 scoreboard drained", 64'(exp_mode_q.size()), 64'd0);
    done = 1;
    report();
  end

endmodule